// File: doc/BRIEF.md
# Memory IO Bank Freeze/Thaw Sequencer

This block freezes and thaws the IO bank that serves an external memory interface. When frozen, the bank holds its pads inert: slew control, weak pull-up, tristate and bus-hold are all active (active low), configuration-done is low, and the regulator, termination-calibration and DLL resets are all asserted while the calibration-start/bias-enable line is low. A one-cycle freeze request or thaw request starts a fixed sequence. The sequence steps through these controls in a safe order. Some of its gaps are counted in system clocks and others are counted in ticks of a slow internal oscillator.

The fixed gaps are `GAP_CYC` system-clock cycles long. The default of 10 cycles at 250 MHz gives 40 ns. The two long waits are `LONG_OSC` (1000) and `SHORT_OSC` (33) oscillator ticks. Ticks arrive on `osc_tick`, a one-cycle pulse synchronous to `clk`. While a sequence runs, `busy` is high and further requests are dropped. The bank leaves reset frozen.

In the requirements, "accept edge" means the clock edge that samples an accepted request. Each step's outputs change at the edge named for it.

Top module: `memio_freeze_seq`

## Requirements
- R1: During and after reset with no request, the outputs show the frozen image and `busy` is 0. The frozen image is: slew_en_n=0, wkpull_n=0, tristate_n=0, bushold_n=0, cfg_done=0, vreg_rst=1, term_rst=1, dll_rst=1, cal_bias_en=0, frozen=1.
- R2: A freeze request is accepted when idle and thawed. At the accept edge, slew_en_n, wkpull_n and tristate_n go to 0 together and `busy` goes to 1.
- R3: `GAP_CYC` cycles after a freeze accept edge, bushold_n goes to 0, cfg_done to 0, vreg_rst to 1 and term_rst to 1.
- R4: `2*GAP_CYC` cycles after a freeze accept edge, cal_bias_en goes to 0, dll_rst to 1 and frozen to 1, and `busy` returns to 0.
- R5: A thaw request is accepted when idle and frozen. At the accept edge, dll_rst goes to 0. cal_bias_en goes to 1 exactly `GAP_CYC` cycles later.
- R6: At the edge that samples the `LONG_OSC`-th tick after cal_bias_en rises, bushold_n goes to 1, cfg_done to 1 and term_rst to 0.
- R7: At the edge that samples the `SHORT_OSC`-th tick after that, wkpull_n and tristate_n go to 1.
- R8: `GAP_CYC` cycles after R7, vreg_rst goes to 0. `GAP_CYC` cycles after that, slew_en_n goes to 1 and frozen to 0, and `busy` returns to 0.
- R9: While `busy` is 1, both requests are ignored, and the running sequence completes unchanged.
- R10: A request for the state the bank is already in leaves every output unchanged and keeps `busy` at 0.
- R11: When freeze and thaw requests are sampled together while idle, freeze wins. The pair does nothing on a frozen bank and starts a freeze on a thawed one.
- R12: Ticks have no effect on the system-clock gaps, and no effect while idle. A tick-counted step happens only on an edge that samples a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frz_req | input | 1 | Freeze request, sampled when idle |
| thaw_req | input | 1 | Thaw request, sampled when idle |
| osc_tick | input | 1 | One-cycle pulse per internal-oscillator cycle |
| slew_en_n | output | 1 | Slew-rate control, active low |
| wkpull_n | output | 1 | Weak pull-up, active low |
| tristate_n | output | 1 | Pad tristate, active low |
| bushold_n | output | 1 | Bus-hold keeper, active low |
| cfg_done | output | 1 | Configuration done, active high |
| vreg_rst | output | 1 | Regulator reset, active high |
| term_rst | output | 1 | Termination-calibration reset, active high |
| dll_rst | output | 1 | DLL reset, active high |
| cal_bias_en | output | 1 | Calibration start / bias enable, active high |
| frozen | output | 1 | Bank is frozen |
| busy | output | 1 | A sequence is in progress |

## Verification
Two things can land on one edge. The first is a freeze request and a thaw request sampled together. The bench raises both in a single cycle, once on a frozen bank and once on a thawed one, and judges the result by whether `busy` rises and slew_en_n falls on the next edge. The second is a step that fires on the same edge as an incoming request, or an oscillator tick that arrives during a system-clock gap. Here the bench pulses requests in mid-sequence and runs ticks on every cycle during a freeze. The reference model then confirms that the step timing does not move by a single cycle.

// File: rtl/memio_fz_pkg.sv
package memio_fz_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_FZ2, PH_FZ3, PH_TH2, PH_TH3, PH_TH4, PH_TH5, PH_TH6
  } phase_e;

  typedef enum logic [3:0] {
    ACT_NONE, ACT_F1, ACT_F2, ACT_F3,
    ACT_T1, ACT_T2, ACT_T3, ACT_T4, ACT_T5, ACT_T6
  } act_e;

  typedef enum logic [1:0] {
    WAIT_GAP, WAIT_LONG, WAIT_SHORT
  } wait_e;

  typedef struct packed {
    logic slew_n;
    logic wkpu_n;
    logic tri_n;
    logic bh_n;
    logic cfg_done;
    logic vreg_rst;
    logic term_rst;
    logic dll_rst;
    logic cal_bias;
    logic frozen;
  } pad_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic pad_t frozen_image();
    pad_t p;
    p.slew_n   = 1'b0;
    p.wkpu_n   = 1'b0;
    p.tri_n    = 1'b0;
    p.bh_n     = 1'b0;
    p.cfg_done = 1'b0;
    p.vreg_rst = 1'b1;
    p.term_rst = 1'b1;
    p.dll_rst  = 1'b1;
    p.cal_bias = 1'b0;
    p.frozen   = 1'b1;
    return p;
  endfunction

  function automatic act_e pending_act(input phase_e ph);
    case (ph)
      PH_FZ2:  return ACT_F2;
      PH_FZ3:  return ACT_F3;
      PH_TH2:  return ACT_T2;
      PH_TH3:  return ACT_T3;
      PH_TH4:  return ACT_T4;
      PH_TH5:  return ACT_T5;
      PH_TH6:  return ACT_T6;
      default: return ACT_NONE;
    endcase
  endfunction

  function automatic phase_e phase_after(input act_e a);
    case (a)
      ACT_F1:  return PH_FZ2;
      ACT_F2:  return PH_FZ3;
      ACT_T1:  return PH_TH2;
      ACT_T2:  return PH_TH3;
      ACT_T3:  return PH_TH4;
      ACT_T4:  return PH_TH5;
      ACT_T5:  return PH_TH6;
      default: return PH_IDLE;
    endcase
  endfunction

  function automatic wait_e wait_of(input phase_e ph);
    case (ph)
      PH_TH3:  return WAIT_LONG;
      PH_TH4:  return WAIT_SHORT;
      default: return WAIT_GAP;
    endcase
  endfunction

  // Initial counter value for a wait. A gap counts down to zero on
  // every clock; a tick wait fires on the tick that meets a count of one.
  function automatic int wait_load(input wait_e w, input int gap,
                                   input int lng, input int shrt);
    case (w)
      WAIT_LONG:  return lng;
      WAIT_SHORT: return shrt;
      default:    return gap - 1;
    endcase
  endfunction

  function automatic pad_t apply_act(input pad_t cur, input act_e a);
    pad_t p;
    p = cur;
    case (a)
      ACT_F1: begin p.slew_n = 1'b0; p.wkpu_n = 1'b0; p.tri_n = 1'b0; end
      ACT_F2: begin
        p.bh_n = 1'b0; p.cfg_done = 1'b0; p.vreg_rst = 1'b1; p.term_rst = 1'b1;
      end
      ACT_F3: begin p.cal_bias = 1'b0; p.dll_rst = 1'b1; p.frozen = 1'b1; end
      ACT_T1: p.dll_rst = 1'b0;
      ACT_T2: p.cal_bias = 1'b1;
      ACT_T3: begin p.bh_n = 1'b1; p.cfg_done = 1'b1; p.term_rst = 1'b0; end
      ACT_T4: begin p.wkpu_n = 1'b1; p.tri_n = 1'b1; end
      ACT_T5: p.vreg_rst = 1'b0;
      ACT_T6: begin p.slew_n = 1'b1; p.frozen = 1'b0; end
      default: p = cur;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/memio_fz_timer.sv
module memio_fz_timer
  import memio_fz_pkg::*;
#(
  parameter int GAP_CYC   = 10,
  parameter int LONG_OSC  = 1000,
  parameter int SHORT_OSC = 33,
  parameter int CNT_W     = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  wait_e kind,
  input  logic  osc_tick,
  output logic  fire,
  output logic  tick_wait
);

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             gap_mode;
  logic [CNT_W-1:0] load_val;

  assign load_val  = CNT_W'(wait_load(kind, GAP_CYC, LONG_OSC, SHORT_OSC));
  assign tick_wait = armed && !gap_mode;
  assign fire      = armed && (gap_mode ? (cnt == '0)
                                        : (osc_tick && cnt == CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      armed    <= 1'b0;
      gap_mode <= 1'b1;
    end else if (load) begin
      cnt      <= load_val;
      armed    <= 1'b1;
      gap_mode <= (kind == WAIT_GAP);
    end else if (fire) begin
      armed <= 1'b0;
    end else if (armed) begin
      if (gap_mode || osc_tick) cnt <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/memio_fz_ctrl.sv
module memio_fz_ctrl
  import memio_fz_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frz_req,
  input  logic  thaw_req,
  input  logic  is_frozen,
  input  logic  fire,
  output act_e  act,
  output logic  load,
  output wait_e kind,
  output logic  busy
);

  phase_e phase;
  phase_e phase_nxt;
  logic   take_frz;
  logic   take_thaw;

  // Freeze has priority; a request for the current state is dropped.
  assign take_frz  = (phase == PH_IDLE) && frz_req && !is_frozen;
  assign take_thaw = (phase == PH_IDLE) && !frz_req && thaw_req && is_frozen;
  assign busy      = (phase != PH_IDLE);

  always_comb begin
    if (take_frz)       act = ACT_F1;
    else if (take_thaw) act = ACT_T1;
    else if (fire)      act = pending_act(phase);
    else                act = ACT_NONE;
  end

  assign phase_nxt = (act == ACT_NONE) ? phase : phase_after(act);
  assign load      = (act != ACT_NONE) && (phase_nxt != PH_IDLE);
  assign kind      = wait_of(phase_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nxt;
  end

endmodule

// File: rtl/memio_fz_pads.sv
module memio_fz_pads
  import memio_fz_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  act_e act,
  output pad_t pads
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pads <= frozen_image();
    else if (act != ACT_NONE)  pads <= apply_act(pads, act);
  end

endmodule

// File: rtl/memio_freeze_seq.sv
module memio_freeze_seq
  import memio_fz_pkg::*;
#(
  parameter int GAP_CYC   = 10,
  parameter int LONG_OSC  = 1000,
  parameter int SHORT_OSC = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frz_req,
  input  logic thaw_req,
  input  logic osc_tick,
  output logic slew_en_n,
  output logic wkpull_n,
  output logic tristate_n,
  output logic bushold_n,
  output logic cfg_done,
  output logic vreg_rst,
  output logic term_rst,
  output logic dll_rst,
  output logic cal_bias_en,
  output logic frozen,
  output logic busy
);

  localparam int MAX_WAIT = max3(GAP_CYC, LONG_OSC, SHORT_OSC);
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  act_e  act;
  logic  load;
  wait_e kind;
  logic  step_fire;
  logic  tick_wait;
  pad_t  pads;

  memio_fz_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .frz_req   (frz_req),
    .thaw_req  (thaw_req),
    .is_frozen (pads.frozen),
    .fire      (step_fire),
    .act       (act),
    .load      (load),
    .kind      (kind),
    .busy      (busy)
  );

  memio_fz_timer #(
    .GAP_CYC   (GAP_CYC),
    .LONG_OSC  (LONG_OSC),
    .SHORT_OSC (SHORT_OSC),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .kind      (kind),
    .osc_tick  (osc_tick),
    .fire      (step_fire),
    .tick_wait (tick_wait)
  );

  memio_fz_pads u_pads (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .pads  (pads)
  );

  assign slew_en_n   = pads.slew_n;
  assign wkpull_n    = pads.wkpu_n;
  assign tristate_n  = pads.tri_n;
  assign bushold_n   = pads.bh_n;
  assign cfg_done    = pads.cfg_done;
  assign vreg_rst    = pads.vreg_rst;
  assign term_rst    = pads.term_rst;
  assign dll_rst     = pads.dll_rst;
  assign cal_bias_en = pads.cal_bias;
  assign frozen      = pads.frozen;

endmodule

// File: rtl/memio_freeze_seq_chk.sv
module memio_freeze_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic frz_req,
  input logic osc_tick,
  input logic slew_en_n,
  input logic wkpull_n,
  input logic tristate_n,
  input logic bushold_n,
  input logic cfg_done,
  input logic vreg_rst,
  input logic term_rst,
  input logic dll_rst,
  input logic cal_bias_en,
  input logic frozen,
  input logic busy,
  input logic step_fire,
  input logic tick_wait
);

  logic [9:0] outs;
  assign outs = {slew_en_n, wkpull_n, tristate_n, bushold_n, cfg_done,
                 vreg_rst, term_rst, dll_rst, cal_bias_en, frozen};

  a_r2_first_freeze_step: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slew_en_n) |-> (!wkpull_n && !tristate_n && busy));

  a_r4_frozen_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> (dll_rst && !cal_bias_en && !bushold_n && !cfg_done && !busy));

  a_r5_cal_after_dll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_bias_en) |-> (!dll_rst && $past(!dll_rst)));

  a_r6_cfg_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> (bushold_n && !term_rst && cal_bias_en && vreg_rst));

  a_r7_pullup_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wkpull_n) |-> (tristate_n && cfg_done && frozen && !slew_en_n));

  a_r8_thaw_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frozen) |-> (slew_en_n && !vreg_rst && !busy && $past(busy)));

  a_r9_idle_outputs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(outs));

  a_r10_no_refreeze: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !busy && frz_req) |=> !busy);

  a_r12_tick_step_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && tick_wait) |-> osc_tick);

endmodule

bind memio_freeze_seq memio_freeze_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frz_req     (frz_req),
  .osc_tick    (osc_tick),
  .slew_en_n   (slew_en_n),
  .wkpull_n    (wkpull_n),
  .tristate_n  (tristate_n),
  .bushold_n   (bushold_n),
  .cfg_done    (cfg_done),
  .vreg_rst    (vreg_rst),
  .term_rst    (term_rst),
  .dll_rst     (dll_rst),
  .cal_bias_en (cal_bias_en),
  .frozen      (frozen),
  .busy        (busy),
  .step_fire   (step_fire),
  .tick_wait   (tick_wait)
);

// File: tb/memio_freeze_seq_tb.sv
`timescale 1ns/1ps
module memio_freeze_seq_tb_top;

  localparam int GAP   = 10;
  localparam int LONGW = 1000;
  localparam int SHRTW = 33;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frz_req = 1'b0;
  logic thaw_req = 1'b0;
  logic osc_tick = 1'b0;
  logic slew_en_n, wkpull_n, tristate_n, bushold_n, cfg_done;
  logic vreg_rst, term_rst, dll_rst, cal_bias_en, frozen, busy;

  always #2 clk = ~clk;

  memio_freeze_seq #(.GAP_CYC(GAP), .LONG_OSC(LONGW), .SHORT_OSC(SHRTW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frz_req(frz_req), .thaw_req(thaw_req),
    .osc_tick(osc_tick), .slew_en_n(slew_en_n), .wkpull_n(wkpull_n),
    .tristate_n(tristate_n), .bushold_n(bushold_n), .cfg_done(cfg_done),
    .vreg_rst(vreg_rst), .term_rst(term_rst), .dll_rst(dll_rst),
    .cal_bias_en(cal_bias_en), .frozen(frozen), .busy(busy)
  );

  int n_checks = 0;
  int n_fail = 0;
  int tick_mode = 0;
  string cur_req = "R1";

  // Behavioural reference: expected pin values in pin order.
  logic [10:0] exp_v;
  int m_seq = 0;     // 0 idle, 1 freeze, 2 thaw
  int m_step = 0;
  int m_left = 0;
  bit m_gap = 1'b1;

  function automatic logic [10:0] act_v();
    return {slew_en_n, wkpull_n, tristate_n, bushold_n, cfg_done, vreg_rst,
            term_rst, dll_rst, cal_bias_en, frozen, busy};
  endfunction

  localparam logic [10:0] FROZEN_V = 11'b000_00_111_0_1_0;
  localparam logic [10:0] THAWED_V = 11'b111_11_000_1_0_0;

  task automatic model_step();
    case (m_seq)
      1: case (m_step)
           1: exp_v[10:8] = 3'b000;
           2: begin exp_v[7] = 0; exp_v[6] = 0; exp_v[5] = 1; exp_v[4] = 1; end
           default: begin exp_v[2] = 0; exp_v[3] = 1; exp_v[1] = 1; end
         endcase
      default: case (m_step)
           1: exp_v[3] = 0;
           2: exp_v[2] = 1;
           3: begin exp_v[7] = 1; exp_v[6] = 1; exp_v[4] = 0; end
           4: begin exp_v[9] = 1; exp_v[8] = 1; end
           5: exp_v[5] = 0;
           default: begin exp_v[10] = 1; exp_v[1] = 0; end
         endcase
    endcase
    if ((m_seq == 1 && m_step == 3) || (m_seq == 2 && m_step == 6)) begin
      m_seq = 0; exp_v[0] = 0;
    end else begin
      m_gap = !(m_seq == 2 && (m_step == 2 || m_step == 3));
      m_left = !m_gap ? ((m_step == 2) ? LONGW : SHRTW) : GAP;
      exp_v[0] = 1;
    end
  endtask

  initial begin
    exp_v = FROZEN_V;
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        exp_v = FROZEN_V; m_seq = 0;
      end else if (m_seq == 0) begin
        if (frz_req && !exp_v[1]) begin
          m_seq = 1; m_step = 1; model_step();
        end else if (thaw_req && !frz_req && exp_v[1]) begin
          m_seq = 2; m_step = 1; model_step();
        end
      end else begin
        if (m_gap || osc_tick) m_left = m_left - 1;
        if (m_left == 0) begin m_step = m_step + 1; model_step(); end
      end
    end
  end

  task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    chk(req, {10'b0, act}, {10'b0, exp});
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  initial forever begin
    @(negedge clk);
    if (rst_n) chk({cur_req, " model"}, act_v(), exp_v);
  end

  // Oscillator tick source: 0 off, 1 every cycle, 2 every third cycle.
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k = (k + 1) % 3;
      osc_tick = (tick_mode == 1) || (tick_mode == 2 && k == 0);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic f, input logic t);
    @(negedge clk); frz_req = f; thaw_req = t;
    @(negedge clk); frz_req = 0; thaw_req = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    cyc(200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 in reset", act_v(), FROZEN_V);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 after reset", act_v(), FROZEN_V);

    // Thaw with sparse ticks; requests during the run are dropped.
    cur_req = "R5"; tick_mode = 2;
    pulse(0, 1);
    chk1("R5 dll_rst low at accept", dll_rst, 1'b0);
    chk1("R5 cal still low", cal_bias_en, 1'b0);
    chk1("R9 busy at accept", busy, 1'b1);
    cyc(GAP - 1);
    chk1("R5 cal low one cycle early", cal_bias_en, 1'b0);
    cyc(1);
    chk1("R5 cal high after gap", cal_bias_en, 1'b1);
    cur_req = "R9";
    cyc(40); pulse(1, 0); cyc(5); pulse(1, 1); cyc(5); pulse(0, 1);
    wait_idle();
    cur_req = "R8";
    chk("R8 thawed image after sparse-tick thaw", act_v(), THAWED_V);

    cur_req = "R10";
    pulse(0, 1);
    chk("R10 thaw on thawed bank", act_v(), THAWED_V);
    cyc(3);

    // Freeze with ticks every cycle: gaps must not move.
    cur_req = "R12"; tick_mode = 1;
    pulse(1, 0);
    chk("R2 first freeze step", act_v(), 11'b000_11_000_1_0_1);
    cyc(GAP - 1);
    chk1("R12 bus-hold not early", bushold_n, 1'b1);
    cyc(1);
    chk("R3 second freeze step", act_v(), 11'b000_00_110_1_0_1);
    cyc(GAP - 1);
    chk1("R12 still busy before last step", busy, 1'b1);
    cyc(1);
    chk("R4 frozen after last step", act_v(), FROZEN_V);

    cur_req = "R10";
    pulse(1, 0);
    chk("R10 freeze on frozen bank", act_v(), FROZEN_V);
    cur_req = "R11";
    pulse(1, 1);
    chk("R11 both requests on frozen bank", act_v(), FROZEN_V);
    cyc(4);

    // Thaw with ticks every cycle: exact tick windows.
    cur_req = "R6";
    pulse(0, 1);
    cyc(GAP);
    chk1("R6 cal high", cal_bias_en, 1'b1);
    cyc(LONGW - 1);
    chk1("R6 bus-hold held one tick early", bushold_n, 1'b0);
    cyc(1);
    chk("R6 cfg-done step", act_v(), 11'b000_11_100_1_1_1);
    cur_req = "R7";
    cyc(SHRTW - 1);
    chk1("R7 pull-up held one tick early", wkpull_n, 1'b0);
    cyc(1);
    chk("R7 pull-up and tristate released", act_v(), 11'b011_11_100_1_1_1);
    cur_req = "R8";
    cyc(GAP);
    chk("R8 regulator reset released", act_v(), 11'b011_11_000_1_1_1);
    cyc(GAP - 1);
    chk1("R8 slew held one cycle early", slew_en_n, 1'b0);
    cyc(1);
    chk("R8 thaw complete", act_v(), THAWED_V);

    cur_req = "R11"; tick_mode = 0;
    pulse(1, 1);
    chk("R11 both requests on thawed bank start freeze", act_v(), 11'b000_11_000_1_0_1);
    wait_idle();
    chk("R11 freeze completes", act_v(), FROZEN_V);

    // Idle ticks change nothing.
    cur_req = "R12"; tick_mode = 1;
    cyc(50);
    chk("R12 idle ticks ignored", act_v(), FROZEN_V);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule